// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block computes a finite impulse response filter output without any multiplier. Incoming signed samples enter a tap delay line. For each output, the block walks through the bit positions of the stored samples, starting at the least significant one. At each position it takes one bit from every tap and forms an address. The address reads a constant table that holds every sum of a subset of the coefficients. A scaling accumulator weights each table result by its bit position and adds it, except at the sign position, where the result is subtracted.

The coefficients are parameters, and the tables are computed at elaboration. Taps are split into groups of at most four. Each group has its own 16-entry table, and the group outputs are added before accumulation. A parameter sets how many bit positions are handled per clock (1, 2, 4 or 8). Each extra bit lane duplicates the tables, and the number of cycles per output drops in proportion. With all bits handled in one clock, the filter accepts one sample on every clock.

The filter takes samples through a valid/ready handshake. It presents each full-precision result with a one-cycle valid strobe.

Top module: `dafir_top`

## Requirements
- R1: For each accepted sample x[n], the result equals the sum over k of C_k * x[n-k] as a signed value `ACC_W = SAMPLE_W + COEF_W + clog2(NUM_TAPS)` bits wide. Tap 0 holds the newest sample. Coefficient k sits in bits `[k*COEF_W +: COEF_W]` of `COEF_VEC`.
- R2: After reset, `out_valid` is 0 and `in_ready` is 1. The delay line holds zeros, so the first outputs treat all earlier samples as zero.
- R3: A sample is taken only on a clock edge where `in_valid` and `in_ready` are both 1, and each taken sample shifts the delay line by exactly one tap. `in_valid` or `in_data` presented while `in_ready` is 0 has no effect on any result.
- R4: `out_valid` is high for exactly one cycle per taken sample. It rises after the clock edge that lies SAMPLE_W/BITS_PER_CLK edges after the accepting edge.
- R5: `in_ready` is 0 while a computation still has more than one cycle to go, and 1 in its final cycle, so samples can be taken back to back. With BITS_PER_CLK equal to SAMPLE_W, `in_ready` stays 1 and one sample is taken on every clock.
- R6: Operands are two's complement. Results are exact for samples and coefficients at the most negative value (-128 for 8 bits).
- R7: BITS_PER_CLK must be 1, 2, 4 or 8 and must divide SAMPLE_W. Other values are rejected at elaboration.
- R8: With two taps, C0 = -7 and C1 = 6, and with tap 0 holding 7 and tap 1 holding 5 (send 5 and then 7), the result is -19.
- R9: Tap counts that are not a multiple of four are exact. The last group table covers only the taps that remain.
- R10: A reset asserted during a computation drops that computation without a result. Later results see a cleared delay line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample at this edge |
| in_data | input | SAMPLE_W | Signed sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | ACC_W | Signed filter result |

## Verification
A sample taken at clock edge k yields its result strobe just after edge k + SAMPLE_W/BITS_PER_CLK. `in_ready` returns high in the last cycle of that window. The bench model keeps a per-sample countdown of that length and updates on the rising edge. The bench compares `in_ready`, `out_valid` and, when a result is due, `out_data` on every falling edge, half a period away from the edges where the design's outputs change. Three instances cover a bit-serial 8-tap filter, a 2-bit-per-clock 2-tap filter and a fully parallel 6-tap filter.

// File: rtl/dafir_pkg.sv
package dafir_pkg;
   // Taps served by one lookup table (4 address bits -> 16 entries)
   localparam int GROUP_TAPS = 4;

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dafir_taps.sv
module dafir_taps #(
   parameter int NUM_TAPS = 8,
   parameter int SAMPLE_W = 8,
   parameter int BPC      = 1,
   parameter int CNT_W    = 3
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              accept,
   input  logic [SAMPLE_W-1:0]               in_data,
   input  logic [CNT_W-1:0]                  cnt,
   output logic [BPC-1:0][NUM_TAPS-1:0]      lane_addr
);
   localparam int IDX_W = $clog2(SAMPLE_W);

   logic [NUM_TAPS-1:0][SAMPLE_W-1:0] taps;

   always_ff @(posedge clk) begin
      if (rst) begin
         taps <= '0;
      end else if (accept) begin
         taps[0] <= in_data;
         for (int k = 1; k < NUM_TAPS; k++) taps[k] <= taps[k-1];
      end
   end

   // One bit from every tap per lane; lane l reads bit cnt*BPC+l
   always_comb begin
      for (int l = 0; l < BPC; l++) begin
         int idx;
         idx = int'(cnt) * BPC + l;
         for (int k = 0; k < NUM_TAPS; k++)
            lane_addr[l][k] = taps[k][idx[IDX_W-1:0]];
      end
   end

   p_shift_r3: assert property (@(posedge clk) disable iff (rst)
      accept |=> taps[0] == $past(in_data));
   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !accept |=> $stable(taps));
endmodule

// File: rtl/dafir_lut.sv
module dafir_lut #(
   parameter int                   TAPS   = 4,
   parameter int                   COEF_W = 8,
   parameter int                   PP_W   = 11,
   parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
   input  logic [TAPS-1:0]         addr,
   output logic signed [PP_W-1:0]  psum
);
   localparam int DEPTH = 2 ** TAPS;

   function automatic logic [DEPTH*PP_W-1:0] build_table();
      logic [DEPTH*PP_W-1:0] t;
      t = '0;
      for (int a = 0; a < DEPTH; a++) begin
         int s;
         s = 0;
         for (int k = 0; k < TAPS; k++)
            if (a[k]) s += int'($signed(COEFS[k*COEF_W +: COEF_W]));
         t[a*PP_W +: PP_W] = PP_W'(s);
      end
      return t;
   endfunction

   localparam logic [DEPTH*PP_W-1:0] TABLE = build_table();

   assign psum = $signed(TABLE[int'(addr)*PP_W +: PP_W]);

   initial begin
      assert (TAPS >= 1 && TAPS <= 4) else $fatal(1, "table address must be 1..4 bits");
   end
endmodule

// File: rtl/dafir_accum.sv
module dafir_accum #(
   parameter int SAMPLE_W = 8,
   parameter int BPC      = 1,
   parameter int CNT_W    = 3,
   parameter int PP_W     = 11,
   parameter int ACC_W    = 19
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              busy,
   input  logic                              last,
   input  logic [CNT_W-1:0]                  cnt,
   input  logic [BPC-1:0][PP_W-1:0]          lane_sum,
   output logic                              out_valid,
   output logic signed [ACC_W-1:0]           out_data
);
   logic signed [ACC_W-1:0] acc, acc_next;

   // Weight each lane by its bit position; the sign position is subtracted
   always_comb begin
      logic signed [ACC_W-1:0] term;
      int bidx;
      acc_next = (cnt == '0) ? '0 : acc;
      for (int l = 0; l < BPC; l++) begin
         bidx = int'(cnt) * BPC + l;
         term = {{(ACC_W-PP_W){lane_sum[l][PP_W-1]}}, lane_sum[l]};
         term = term << bidx;
         if (bidx == SAMPLE_W - 1) acc_next = acc_next - term;
         else                      acc_next = acc_next + term;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= last;
         if (busy) acc <= acc_next;
         if (last) out_data <= acc_next;
      end
   end
endmodule

// File: rtl/dafir_top.sv
module dafir_top #(
   parameter int NUM_TAPS     = 8,
   parameter int SAMPLE_W     = 8,
   parameter int COEF_W       = 8,
   parameter int BITS_PER_CLK = 1,
   parameter logic [NUM_TAPS*COEF_W-1:0] COEF_VEC = 64'h6400FF4DCE037F80,
   localparam int ACC_W = SAMPLE_W + COEF_W + $clog2(NUM_TAPS)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [SAMPLE_W-1:0]         in_data,
   output logic                        out_valid,
   output logic signed [ACC_W-1:0]     out_data
);
   import dafir_pkg::*;

   localparam int NCYC  = SAMPLE_W / BITS_PER_CLK;
   localparam int CNT_W = cnt_width(NCYC);
   localparam int NGRP  = ceil_div(NUM_TAPS, GROUP_TAPS);
   localparam int PP_W  = COEF_W + $clog2(NUM_TAPS);

   // R7: legal lane counts only
   initial begin
      assert (BITS_PER_CLK == 1 || BITS_PER_CLK == 2 || BITS_PER_CLK == 4 || BITS_PER_CLK == 8)
         else $fatal(1, "BITS_PER_CLK must be 1, 2, 4 or 8");
      assert (SAMPLE_W % BITS_PER_CLK == 0) else $fatal(1, "BITS_PER_CLK must divide SAMPLE_W");
      assert (SAMPLE_W >= 2 && COEF_W >= 2 && NUM_TAPS >= 1) else $fatal(1, "bad widths");
   end

   // Bit-position sequencer
   logic             busy, last, accept;
   logic [CNT_W-1:0] cnt;

   assign last     = busy && (cnt == CNT_W'(NCYC - 1));
   assign in_ready = !busy || last;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (accept) begin
         busy <= 1'b1;
         cnt  <= '0;
      end else if (last) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         cnt  <= cnt + 1'b1;
      end
   end

   logic [BITS_PER_CLK-1:0][NUM_TAPS-1:0] lane_addr;

   dafir_taps #(
      .NUM_TAPS(NUM_TAPS), .SAMPLE_W(SAMPLE_W), .BPC(BITS_PER_CLK), .CNT_W(CNT_W)
   ) u_taps (
      .clk(clk), .rst(rst), .accept(accept), .in_data(in_data),
      .cnt(cnt), .lane_addr(lane_addr)
   );

   // One table per (lane, group of up to four taps); R9 partial last group
   logic signed [PP_W-1:0] grp_sum [BITS_PER_CLK][NGRP];
   logic [BITS_PER_CLK-1:0][PP_W-1:0] lane_sum;

   for (genvar l = 0; l < BITS_PER_CLK; l++) begin : g_lane
      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         localparam int BASE = g * GROUP_TAPS;
         localparam int GT   = (NUM_TAPS - BASE >= GROUP_TAPS) ? GROUP_TAPS : NUM_TAPS - BASE;
         dafir_lut #(
            .TAPS(GT), .COEF_W(COEF_W), .PP_W(PP_W),
            .COEFS(COEF_VEC[BASE*COEF_W +: GT*COEF_W])
         ) u_lut (
            .addr(lane_addr[l][BASE +: GT]),
            .psum(grp_sum[l][g])
         );
      end
      // Pre-adder joining the group tables of this lane
      always_comb begin
         logic signed [PP_W-1:0] s;
         s = '0;
         for (int g = 0; g < NGRP; g++) s = s + grp_sum[l][g];
         lane_sum[l] = s;
      end
   end

   dafir_accum #(
      .SAMPLE_W(SAMPLE_W), .BPC(BITS_PER_CLK), .CNT_W(CNT_W), .PP_W(PP_W), .ACC_W(ACC_W)
   ) u_acc (
      .clk(clk), .rst(rst), .busy(busy), .last(last), .cnt(cnt),
      .lane_sum(lane_sum), .out_valid(out_valid), .out_data(out_data)
   );

   p_clear_r2: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (in_ready && !out_valid));
   p_done_r4: assert property (@(posedge clk) disable iff (rst)
      last |=> out_valid);
   p_cause_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(busy));
   if (NCYC > 1) begin : g_pulse
      p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
         out_valid |=> !out_valid);
      p_wait_r5: assert property (@(posedge clk) disable iff (rst)
         accept |=> !in_ready);
   end
endmodule

// File: tb/dafir_env.sv
module dafir_env #(
   parameter int NUM_TAPS = 8,
   parameter int BPC      = 1,
   parameter logic [NUM_TAPS*8-1:0] COEF_VEC = '0,
   parameter int NRAND    = 40
) (
   input  logic clk,
   output logic done
);
   localparam int SW    = 8;
   localparam int NCYC  = SW / BPC;
   localparam int ACC_W = SW + 8 + $clog2(NUM_TAPS);

   logic                     rst;
   logic                     in_valid;
   logic                     in_ready;
   logic [SW-1:0]            in_data;
   logic                     out_valid;
   logic signed [ACC_W-1:0]  out_data;

   int    errors, checks, nres;
   longint log_out [4];
   string data_tag;

   dafir_top #(
      .NUM_TAPS(NUM_TAPS), .SAMPLE_W(SW), .COEF_W(8),
      .BITS_PER_CLK(BPC), .COEF_VEC(COEF_VEC)
   ) i_dafir_top (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
   );

   // ---- behavioural model: history of samples and a countdown ----
   longint hist [NUM_TAPS];
   bit     pend, exp_ov;
   int     pend_cnt;
   longint pend_val, exp_data;

   function automatic longint coef(input int k);
      return longint'($signed(COEF_VEC[k*8 +: 8]));
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NUM_TAPS; k++) hist[k] = 0;
         pend = 0; pend_cnt = 0; exp_ov = 0;
      end else begin
         bit rdy;
         rdy = !pend || pend_cnt == 1;
         exp_ov = 0;
         if (pend) begin
            if (pend_cnt == 1) begin
               exp_ov = 1; exp_data = pend_val; pend = 0;
            end else pend_cnt--;
         end
         if (in_valid && rdy) begin
            longint y;
            for (int k = NUM_TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'($signed(in_data));
            y = 0;
            for (int k = 0; k < NUM_TAPS; k++) y += coef(k) * hist[k];
            pend = 1; pend_cnt = NCYC; pend_val = y;
         end
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s taps=%0d bpc=%0d t=%0t actual=%0d expected=%0d",
                  req, NUM_TAPS, BPC, $time, act, exp);
      end
   endtask

   // Compare on every falling edge
   always @(negedge clk) begin
      if (!rst) begin
         check("R5", longint'(in_ready), longint'(!pend || pend_cnt == 1));
         check("R4", longint'(out_valid), longint'(exp_ov));
         if (exp_ov && out_valid) begin
            check(data_tag, longint'(out_data), exp_data);   // R1, R6, R9
            if (nres < 4) log_out[nres] = longint'(out_data);
            nres++;
            data_tag = "R1";
         end
      end
   end

   task automatic send(input logic [SW-1:0] x);
      bit r;
      in_valid = 1; in_data = x;
      do begin
         r = in_ready;
         @(negedge clk);
      end while (!r);
      in_valid = 0;
      // R3: garbage on in_data while idle must not matter
      in_data = SW'($urandom);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      errors = 0; checks = 0; nres = 0; done = 0; data_tag = "R1";
      rst = 1; in_valid = 0; in_data = '0;
      idle(3);
      check("R2", longint'(in_ready), 1);
      check("R2", longint'(out_valid), 0);
      rst = 0;
      data_tag = "R2";
      // R8 pattern first (5 then 7), then R6 extremes
      send(8'd5); send(8'd7);
      send(8'h80); send(8'h80); send(8'h7F); send(8'hFF); send(8'h00);
      // back-to-back plus random gaps; in_valid held during busy (R3)
      for (int i = 0; i < NRAND; i++) begin
         send(SW'($urandom));
         idle($urandom_range(0, 2));
      end
      // R10: reset in the middle of a computation
      send(8'h81);
      rst = 1; idle(2); rst = 0;
      data_tag = "R10";
      for (int i = 0; i < NRAND; i++) begin
         send(SW'($urandom));
         if (i % 3 == 0) idle($urandom_range(0, 3));
      end
      idle(NCYC + 3);
      done = 1;
   end
endmodule

// File: tb/test_dafir_top.sv
module test_dafir_top;
   logic clk = 0;
   always #2 clk = ~clk;   // 250 MHz

   logic done_a, done_b, done_c;
   int   errors, checks;
   bit   timed_out;

   // Bit-serial, eight taps in two full groups, extreme coefficients
   dafir_env #(.NUM_TAPS(8), .BPC(1), .COEF_VEC(64'h6400FF4DCE037F80), .NRAND(60))
      e_a (.clk(clk), .done(done_a));
   // Two taps, C0 = -7, C1 = 6, two bits per clock
   dafir_env #(.NUM_TAPS(2), .BPC(2), .COEF_VEC(16'h06F9), .NRAND(50))
      e_b (.clk(clk), .done(done_b));
   // Six taps (R9 partial group), fully parallel (R5 one per clock)
   dafir_env #(.NUM_TAPS(6), .BPC(8), .COEF_VEC(48'h147FF7378080), .NRAND(80))
      e_c (.clk(clk), .done(done_c));

   initial begin
      timed_out = 0;
      for (int i = 0; i < 150000; i++) begin
         @(posedge clk);
         if (done_a && done_b && done_c) break;
         if (i == 149999) timed_out = 1;
      end
      @(negedge clk);
      errors = e_a.errors + e_b.errors + e_c.errors;
      checks = e_a.checks + e_b.checks + e_c.checks;
      checks++;
      if (timed_out) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      // R8: second result of the two-tap filter
      checks++;
      if (e_b.log_out[1] != -19) begin
         errors++;
         $display("FAIL R8 actual=%0d expected=-19", e_b.log_out[1]);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule